// File: doc/BRIEF.md
# Transmit FIFO with Start Thresholds

This block buffers 64-bit words between a DMA-style producer and a transmit-side consumer on one clock. Each stored word carries a first-word and a last-word marker for its packet. The producer is told that it may send only once enough free slots exist for a whole burst. The consumer is told that it may begin a packet only once enough of that packet is buffered, or once the packet's final word has arrived. This keeps a started transmission from running dry.

The write threshold, the read threshold and a DMA burst selection are captured into internal registers by a load strobe. In DMA mode the write threshold is fixed at 4 or 8 slots, chosen by the burst selection. A configuration-error output reports combinations whose thresholds together exceed the buffer depth. Writes into a full buffer and reads from an empty one are dropped, and each sets its own sticky flag.

Top module: `txq_threshold_fifo`

## Requirements
- R1: Accepted words leave in write order, together with their first/last markers. The head word is visible on `rd_data`, `rd_sop` and `rd_eop` without a read request, and it advances one cycle after an accepted read.
- R2: Threshold and mode settings take effect only in the cycle after `cfg_we` is high. After reset both thresholds are 0 and DMA mode is off, whatever the configuration inputs carry.
- R3: `space_avail` is high exactly when (DEPTH − `level`) ≥ the effective write threshold. With DMA mode off the effective write threshold is the stored write threshold. With DMA mode on it is 8 when the burst selection is 1 and 4 when it is 0.
- R4: When no packet is in progress, `start_tx` is high exactly when the buffer is non-empty and either `level` ≥ the stored read threshold or at least one stored word carries the last-word marker.
- R5: A read request while no packet is in progress and `start_tx` is low is ignored: `level` and the head word do not change.
- R6: Reading a word without the last-word marker opens a packet. While a packet is open, `start_tx` is low and every read request on a non-empty buffer is accepted. Reading a word with the last-word marker closes the packet.
- R7: `cfg_err` is high exactly when the effective write threshold plus the stored read threshold exceeds DEPTH.
- R8: A write request while `full` is high is dropped. It leaves `level` and the stored words unchanged, and it sets `overflow`, which stays high until reset.
- R9: A read request while `empty` is high is dropped and sets `underflow`, which stays high until reset.
- R10: `level` counts the stored words, from 0 to DEPTH. `empty` is high at 0 and `full` is high at DEPTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Load strobe for the configuration inputs |
| cfg_wr_thr | input | 7 | Free-slot threshold for space indication |
| cfg_rd_thr | input | 7 | Buffered-word threshold for packet start |
| cfg_dma_en | input | 1 | Use a fixed DMA write threshold |
| cfg_dma_burst8 | input | 1 | DMA write threshold 8 (1) or 4 (0) |
| wr_en | input | 1 | Write request |
| wr_data | input | 64 | Write word |
| wr_sop | input | 1 | Write word is first of packet |
| wr_eop | input | 1 | Write word is last of packet |
| rd_en | input | 1 | Read request |
| rd_data | output | 64 | Head word |
| rd_sop | output | 1 | Head word first-of-packet marker |
| rd_eop | output | 1 | Head word last-of-packet marker |
| space_avail | output | 1 | Enough free slots for the producer |
| start_tx | output | 1 | Consumer may begin the next packet |
| cfg_err | output | 1 | Thresholds together exceed the depth |
| level | output | $clog2(DEPTH+1) | Stored word count |
| empty | output | 1 | No word stored |
| full | output | 1 | DEPTH words stored |
| overflow | output | 1 | Sticky dropped-write flag |
| underflow | output | 1 | Sticky dropped-read flag |

## Verification
On every cycle the assertions check that the count stays within bounds and moves by at most one, that the drop flags are sticky, that a full buffer never gains a word, that an ungated idle read never lowers the count, that `start_tx` never rises on an empty buffer, and that stored thresholds hold without a load strobe. The exact threshold arithmetic, word ordering, marker-driven early start and the DMA threshold choice are shown only by the bench. It sweeps every fill level of a 32-deep buffer against every 7-bit threshold value and runs directed packet scenarios.

// File: rtl/txq_pkg.sv
// Package: shared constants and the stored-entry type for the transmit FIFO.
// Assumes a fixed 64-bit payload; depth is chosen by the top-level parameter.
package txq_pkg;
    localparam int TXQ_DATA_W      = 64;
    localparam int TXQ_THR_W       = 7;
    localparam int TXQ_DMA_THR_LO  = 4;
    localparam int TXQ_DMA_THR_HI  = 8;

    typedef struct packed {
        logic                  sop;
        logic                  eop;
        logic [TXQ_DATA_W-1:0] data;
    } txq_entry_t;
endpackage

// File: rtl/txq_store.sv
// Module: txq_store
// Circular storage with write and read pointers. The head entry is presented
// combinationally. Assumes DEPTH is a power of two and that the caller only
// fires writes when not full and reads when not empty.
module txq_store
    import txq_pkg::*;
#(
    parameter int DEPTH = 32
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_fire,
    input  txq_entry_t wr_entry,
    input  logic       rd_fire,
    output txq_entry_t head
);
    localparam int AW = $clog2(DEPTH);

    txq_entry_t     mem [DEPTH];
    logic [AW-1:0]  wr_ptr;
    logic [AW-1:0]  rd_ptr;

    // Advance the pointers on accepted transfers; they wrap at the power-of-two depth.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            if (wr_fire) wr_ptr <= wr_ptr + AW'(1);
            if (rd_fire) rd_ptr <= rd_ptr + AW'(1);
        end
    end

    // Capture the written entry; the storage itself needs no reset.
    always_ff @(posedge clk) begin
        if (wr_fire) mem[wr_ptr] <= wr_entry;
    end

    // Present the head entry without waiting for a read request.
    assign head = mem[rd_ptr];
endmodule

// File: rtl/txq_occupancy.sv
// Module: txq_occupancy
// Accepts or drops write and read requests. Tracks the word count, the number
// of stored last-word markers, the open-packet state and the sticky drop flags.
// Assumes start_tx comes from registered state only, so there is no combinational loop.
module txq_occupancy #(
    parameter int DEPTH = 32,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_eop,
    input  logic             rd_en,
    input  logic             head_eop,
    input  logic             start_tx,
    output logic             wr_fire,
    output logic             rd_fire,
    output logic [CNT_W-1:0] count,
    output logic [CNT_W-1:0] eop_pending,
    output logic             in_pkt,
    output logic             empty,
    output logic             full,
    output logic             overflow,
    output logic             underflow
);
    // Derive the occupancy flags from the count.
    assign empty = (count == '0);
    assign full  = (count == CNT_W'(DEPTH));

    // Accept a write only with room; accept a read only with data and an open packet or a start grant.
    assign wr_fire = wr_en && !full;
    assign rd_fire = rd_en && !empty && (in_pkt || start_tx);

    // Keep the word count and the stored last-word marker count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count       <= '0;
            eop_pending <= '0;
        end else begin
            case ({wr_fire, rd_fire})
                2'b10:   count <= count + CNT_W'(1);
                2'b01:   count <= count - CNT_W'(1);
                default: count <= count;
            endcase
            case ({wr_fire && wr_eop, rd_fire && head_eop})
                2'b10:   eop_pending <= eop_pending + CNT_W'(1);
                2'b01:   eop_pending <= eop_pending - CNT_W'(1);
                default: eop_pending <= eop_pending;
            endcase
        end
    end

    // Open a packet on reading a non-last word and close it on reading a last word.
    always_ff @(posedge clk) begin
        if (!rst_n)       in_pkt <= 1'b0;
        else if (rd_fire) in_pkt <= !head_eop;
    end

    // Latch dropped-transfer events until reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            overflow  <= 1'b0;
            underflow <= 1'b0;
        end else begin
            overflow  <= overflow  || (wr_en && full);
            underflow <= underflow || (rd_en && empty);
        end
    end

    assert_count_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_W'(DEPTH));
    assert_count_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ##1 ((count == $past(count)) || (count == $past(count) + CNT_W'(1)) ||
             (count == $past(count) - CNT_W'(1))));
    assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        full |=> (count <= $past(count)));
    assert_overflow_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow);
    assert_underflow_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        underflow |=> underflow);
    assert_idle_read_gated_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !wr_en && !in_pkt && !start_tx) |=> (count == $past(count)));
endmodule

// File: rtl/txq_thresholds.sv
// Module: txq_thresholds
// Holds the threshold configuration and derives the space-available, start
// and configuration-error flags from it. Assumes count and eop_pending come
// from registered state.
module txq_thresholds
    import txq_pkg::*;
#(
    parameter int DEPTH = 32,
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int CMP_W = ((CNT_W > TXQ_THR_W) ? CNT_W : TXQ_THR_W) + 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_we,
    input  logic [TXQ_THR_W-1:0] cfg_wr_thr,
    input  logic [TXQ_THR_W-1:0] cfg_rd_thr,
    input  logic                 cfg_dma_en,
    input  logic                 cfg_dma_burst8,
    input  logic [CNT_W-1:0]     count,
    input  logic [CNT_W-1:0]     eop_pending,
    input  logic                 in_pkt,
    input  logic                 empty,
    output logic                 space_avail,
    output logic                 start_tx,
    output logic                 cfg_err
);
    logic [TXQ_THR_W-1:0] wr_thr_q;
    logic [TXQ_THR_W-1:0] rd_thr_q;
    logic                 dma_q;
    logic                 burst8_q;
    logic [CMP_W-1:0]     wr_eff;
    logic [CMP_W-1:0]     rd_w;
    logic [CMP_W-1:0]     free_w;
    logic [CMP_W-1:0]     cnt_w;

    // Capture configuration on the load strobe; everything clears on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_thr_q <= '0;
            rd_thr_q <= '0;
            dma_q    <= 1'b0;
            burst8_q <= 1'b0;
        end else if (cfg_we) begin
            wr_thr_q <= cfg_wr_thr;
            rd_thr_q <= cfg_rd_thr;
            dma_q    <= cfg_dma_en;
            burst8_q <= cfg_dma_burst8;
        end
    end

    // Pick the effective write threshold and widen the operands for comparison.
    always_comb begin
        if (dma_q) wr_eff = burst8_q ? CMP_W'(TXQ_DMA_THR_HI) : CMP_W'(TXQ_DMA_THR_LO);
        else       wr_eff = CMP_W'(wr_thr_q);
        rd_w   = CMP_W'(rd_thr_q);
        cnt_w  = CMP_W'(count);
        free_w = CMP_W'(DEPTH) - cnt_w;
    end

    // Derive the three flags from the stored settings and the occupancy.
    always_comb begin
        space_avail = (free_w >= wr_eff);
        start_tx    = !in_pkt && !empty && ((cnt_w >= rd_w) || (eop_pending != '0));
        cfg_err     = ((wr_eff + rd_w) > CMP_W'(DEPTH));
    end

    assert_start_needs_data_R4: assert property (@(posedge clk) disable iff (!rst_n)
        start_tx |-> (count != '0));
    assert_cfg_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_we |=> ($stable(rd_thr_q) && $stable(wr_thr_q) && $stable(dma_q)));
    assert_no_start_in_pkt_R6: assert property (@(posedge clk) disable iff (!rst_n)
        in_pkt |-> !start_tx);
endmodule

// File: rtl/txq_threshold_fifo.sv
// Module: txq_threshold_fifo
// Transmit FIFO top: storage, occupancy control and threshold flags.
// Assumes a single clock and DEPTH of 32 or 128 (a power of two).
module txq_threshold_fifo
    import txq_pkg::*;
#(
    parameter int DEPTH = 32,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_we,
    input  logic [TXQ_THR_W-1:0]  cfg_wr_thr,
    input  logic [TXQ_THR_W-1:0]  cfg_rd_thr,
    input  logic                  cfg_dma_en,
    input  logic                  cfg_dma_burst8,
    input  logic                  wr_en,
    input  logic [TXQ_DATA_W-1:0] wr_data,
    input  logic                  wr_sop,
    input  logic                  wr_eop,
    input  logic                  rd_en,
    output logic [TXQ_DATA_W-1:0] rd_data,
    output logic                  rd_sop,
    output logic                  rd_eop,
    output logic                  space_avail,
    output logic                  start_tx,
    output logic                  cfg_err,
    output logic [CNT_W-1:0]      level,
    output logic                  empty,
    output logic                  full,
    output logic                  overflow,
    output logic                  underflow
);
    txq_entry_t       wr_entry;
    txq_entry_t       head;
    logic             wr_fire;
    logic             rd_fire;
    logic [CNT_W-1:0] eop_pending;
    logic             in_pkt;

    // Pack the write side into one entry and unpack the head for the reader.
    always_comb begin
        wr_entry = '{sop: wr_sop, eop: wr_eop, data: wr_data};
        rd_data  = head.data;
        rd_sop   = head.sop;
        rd_eop   = head.eop;
    end

    txq_store #(.DEPTH(DEPTH)) u_store (
        .clk(clk), .rst_n(rst_n), .wr_fire(wr_fire), .wr_entry(wr_entry),
        .rd_fire(rd_fire), .head(head)
    );

    txq_occupancy #(.DEPTH(DEPTH)) u_occ (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_eop(wr_eop), .rd_en(rd_en),
        .head_eop(head.eop), .start_tx(start_tx), .wr_fire(wr_fire), .rd_fire(rd_fire),
        .count(level), .eop_pending(eop_pending), .in_pkt(in_pkt), .empty(empty),
        .full(full), .overflow(overflow), .underflow(underflow)
    );

    txq_thresholds #(.DEPTH(DEPTH)) u_thr (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wr_thr(cfg_wr_thr),
        .cfg_rd_thr(cfg_rd_thr), .cfg_dma_en(cfg_dma_en), .cfg_dma_burst8(cfg_dma_burst8),
        .count(level), .eop_pending(eop_pending), .in_pkt(in_pkt), .empty(empty),
        .space_avail(space_avail), .start_tx(start_tx), .cfg_err(cfg_err)
    );
endmodule

// File: tb/tb_txq_threshold_fifo.sv
// Bench: sweeps every fill level of a 32-deep FIFO against every threshold
// value, then runs directed packet, drop and DMA scenarios.
module tb_txq_threshold_fifo;
    localparam int DEPTH = 32;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cfg_we = 1'b0;
    logic [6:0]       cfg_wr_thr = '0;
    logic [6:0]       cfg_rd_thr = '0;
    logic             cfg_dma_en = 1'b0;
    logic             cfg_dma_burst8 = 1'b0;
    logic             wr_en = 1'b0;
    logic [63:0]      wr_data = '0;
    logic             wr_sop = 1'b0;
    logic             wr_eop = 1'b0;
    logic             rd_en = 1'b0;
    logic [63:0]      rd_data;
    logic             rd_sop, rd_eop, space_avail, start_tx, cfg_err;
    logic [CNT_W-1:0] level;
    logic             empty, full, overflow, underflow;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    txq_threshold_fifo #(.DEPTH(DEPTH)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wr_thr(cfg_wr_thr),
        .cfg_rd_thr(cfg_rd_thr), .cfg_dma_en(cfg_dma_en), .cfg_dma_burst8(cfg_dma_burst8),
        .wr_en(wr_en), .wr_data(wr_data), .wr_sop(wr_sop), .wr_eop(wr_eop), .rd_en(rd_en),
        .rd_data(rd_data), .rd_sop(rd_sop), .rd_eop(rd_eop), .space_avail(space_avail),
        .start_tx(start_tx), .cfg_err(cfg_err), .level(level), .empty(empty), .full(full),
        .overflow(overflow), .underflow(underflow)
    );

    task automatic check(input longint act, input longint exp, input string tag);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) cyc();
        rst_n = 1'b1;
    endtask

    task automatic push(input logic [63:0] d, input logic s, input logic e);
        wr_en = 1'b1; wr_data = d; wr_sop = s; wr_eop = e;
        cyc();
        wr_en = 1'b0; wr_sop = 1'b0; wr_eop = 1'b0;
    endtask

    task automatic pop();
        rd_en = 1'b1;
        cyc();
        rd_en = 1'b0;
    endtask

    task automatic setcfg(input int wt, input int rt, input bit dma, input bit b8);
        cfg_we = 1'b1; cfg_wr_thr = 7'(wt); cfg_rd_thr = 7'(rt);
        cfg_dma_en = dma; cfg_dma_burst8 = b8;
        cyc();
        cfg_we = 1'b0;
    endtask

    function automatic logic [63:0] pat(input int i);
        return 64'hC0DE_0000_0000_0000 | 64'(i);
    endfunction

    initial begin
        cyc();
        do_reset();
        // Reset state (R10, R2)
        check(level, 0, "R10 level after reset");
        check(empty, 1, "R10 empty after reset");
        check(full, 0, "R10 full after reset");
        check(overflow, 0, "R8 overflow after reset");
        check(underflow, 0, "R9 underflow after reset");
        check(space_avail, 1, "R2 space with zero threshold after reset");

        // Sweep fill level 0..DEPTH against every 7-bit threshold (R3, R4, R7, R10)
        for (int lv = 0; lv <= DEPTH; lv++) begin
            for (int t = 0; t < 128; t++) begin
                setcfg(t, t, 1'b0, 1'b0);
                check(space_avail, (DEPTH - lv) >= t, $sformatf("R3 space lv=%0d thr=%0d", lv, t));
                check(start_tx, (lv > 0) && (lv >= t), $sformatf("R4 start lv=%0d thr=%0d", lv, t));
                check(cfg_err, (2 * t) > DEPTH, $sformatf("R7 cfg_err thr=%0d", t));
            end
            check(level, lv, "R10 level during fill");
            check(full, lv == DEPTH, "R10 full during fill");
            if (lv < DEPTH) push(pat(lv), lv == 0, 1'b0);
        end

        // Write into a full buffer is dropped (R8)
        push(64'hDEAD, 1'b0, 1'b0);
        check(level, DEPTH, "R8 level after full write");
        check(overflow, 1, "R8 overflow set");
        check(rd_data, pat(0), "R8 head unchanged");

        // Drain in order (R1, R6)
        setcfg(0, 0, 1'b0, 1'b0);
        for (int i = 0; i < DEPTH; i++) begin
            check(rd_data, pat(i), $sformatf("R1 data order %0d", i));
            check(rd_sop, i == 0, "R1 sop marker");
            pop();
        end
        check(empty, 1, "R10 empty after drain");
        check(overflow, 1, "R8 overflow sticky");
        pop();
        check(underflow, 1, "R9 underflow set");
        check(level, 0, "R9 level after empty read");
        push(pat(7), 1'b0, 1'b0);
        check(underflow, 1, "R9 underflow sticky");

        // Configuration inputs ignored without load strobe (R2)
        do_reset();
        cfg_wr_thr = 7'd40; cfg_rd_thr = 7'd20;
        push(pat(1), 1'b1, 1'b0);
        check(start_tx, 1, "R2 unloaded read threshold stays zero");
        check(space_avail, 1, "R2 unloaded write threshold stays zero");
        check(cfg_err, 0, "R2 unloaded cfg_err");

        // Idle read gated by the read threshold, then drain once open (R5, R6, R1)
        do_reset();
        setcfg(0, 4, 1'b0, 1'b0);
        push(pat(10), 1'b1, 1'b0);
        push(pat(11), 1'b0, 1'b0);
        check(start_tx, 0, "R4 below read threshold");
        pop();
        check(level, 2, "R5 gated read level");
        check(rd_data, pat(10), "R5 gated read head");
        check(underflow, 0, "R5 gated read no underflow");
        push(pat(12), 1'b0, 1'b0);
        push(pat(13), 1'b0, 1'b1);
        check(start_tx, 1, "R4 threshold reached");
        pop();
        check(level, 3, "R6 first read accepted");
        check(start_tx, 0, "R6 start low inside packet");
        pop();
        pop();
        check(rd_eop, 1, "R1 eop marker on last");
        check(rd_data, pat(13), "R6 drain below threshold");
        pop();
        check(level, 0, "R6 packet drained");

        // Early start on stored last word (R4)
        setcfg(0, 10, 1'b0, 1'b0);
        push(pat(20), 1'b1, 1'b0);
        push(pat(21), 1'b0, 1'b0);
        check(start_tx, 0, "R4 no eop yet");
        push(pat(22), 1'b0, 1'b1);
        check(start_tx, 1, "R4 eop stored starts early");
        pop(); pop(); pop();
        check(level, 0, "R4 short packet drained");
        check(start_tx, 0, "R4 start low when empty");

        // DMA write threshold selection (R3, R7)
        for (int lv = 0; lv <= DEPTH; lv++) begin
            setcfg(100, 0, 1'b1, 1'b0);
            check(space_avail, (DEPTH - lv) >= 4, $sformatf("R3 dma4 lv=%0d", lv));
            check(cfg_err, 0, "R7 dma4 no error");
            setcfg(100, 0, 1'b1, 1'b1);
            check(space_avail, (DEPTH - lv) >= 8, $sformatf("R3 dma8 lv=%0d", lv));
            if (lv < DEPTH) push(pat(lv), 1'b0, 1'b0);
        end
        setcfg(0, 24, 1'b1, 1'b1);
        check(cfg_err, 0, "R7 dma8 plus 24 fits");
        setcfg(0, 25, 1'b1, 1'b1);
        check(cfg_err, 1, "R7 dma8 plus 25 exceeds");
        setcfg(0, 28, 1'b1, 1'b0);
        check(cfg_err, 0, "R7 dma4 plus 28 fits");
        setcfg(0, 29, 1'b1, 1'b0);
        check(cfg_err, 1, "R7 dma4 plus 29 exceeds");

        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #2000000;
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule